// File: doc/BRIEF.md
# Peripheral master clock generator

This block derives one master clock for a peripheral from a single 32-bit control word. A two-bit field picks one of four source clocks: the system clock, the reference clock, an external master-clock input, or a fourth external input. An enable bit gates the chosen source. A 15-bit divider then stretches the gated clock by the programmed ratio. An optional output stage can replace the divider output with an alternate receive-side clock.

The whole block runs on one fast sampling clock. The source clocks arrive as slow levels and are sampled into that domain. The divider advances on detected source edges instead of being clocked by the sources, so the logic stays synchronous. Software changes the divider in three writes. The first write clears the enable bit. The second writes the new ratio with the enable still clear. The third writes the same ratio with the enable set. After reset the word is zero and the output is held low. Initialisation software normally loads a ratio that makes the output run at the peripheral bus rate.

Top module: `mclk_gen`

## Requirements
- R1: After reset the control word reads as zero and `mclk_out` is low.
- R2: While the enable bit (bit 16) is 0, the divider output is held low whatever the sources do.
- R3: Bits 15:14 pick the source: 0 selects `src_clk[0]` (system), 1 selects `src_clk[1]` (reference), 2 selects `src_clk[2]` (external master-clock input) and 3 selects `src_clk[3]` (fourth external input).
- R4: With field value D in bits 31:17, the output period is D+1 periods of the selected source.
- R5: A field value of 0 passes the selected source through unchanged. The output high time equals the source high time.
- R6: For a ratio N of 2 or more, the high phase lasts ceil(N/2) source periods and the low phase lasts floor(N/2). An odd N therefore gives a high phase one source period longer than the low phase.
- R7: The divider reloads its ratio immediately while the enable bit is 0. While the enable bit is 1, a new ratio takes effect only after the period in progress has completed.
- R8: The output rises only on a source rising edge. When the gate opens while the source is high, the first output pulse is a full-length pulse and not a runt.
- R9: A read returns the last written word ANDed with a mask. The mask keeps bits 31:14 and, when the output stage exists, bit 7. All other bits read as 0.
- R10: When the output stage exists, bit 7 = 1 routes `alt_clk` to `mclk_out`, and bit 7 = 0 routes the divider output.
- R11: The largest field value, 32767, gives a period of 32768 source periods with a high phase of 16384 source periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads `wr_data` into the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Current control word after masking |
| src_clk | input | 4 | Four source clock levels, index = select code |
| alt_clk | input | 1 | Alternate receive-side clock for the output stage |
| mclk_out | output | 1 | Generated master clock |

## Verification
The bench builds the block with its default parameters: a 15-bit divider, a 2-bit source select and the output stage present. With these parameters the full 32768 ratio can be reached, and bit 7 routing to `alt_clk` can be checked. Each of the four sources is given a different period in the bench, so a wrong select shows up as a wrong measured period. Both odd and even ratios and pass-through are measured against bench formulas. A ratio is also rewritten while the gate is open, to show that the running period completes first.

// File: rtl/mclk_gen_pkg.sv
package mclk_gen_pkg;

   localparam int WORD_W  = 32;
   localparam int ALT_BIT = 7;
   localparam int SEL_LSB = 14;
   localparam int EN_BIT  = 16;
   localparam int DIV_LSB = 17;

   function automatic logic [WORD_W-1:0] field_mask(int sel_w, int div_w, bit has_alt);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < WORD_W; i++) begin
         if (i >= SEL_LSB && i < SEL_LSB + sel_w) m[i] = 1'b1;
         if (i == EN_BIT) m[i] = 1'b1;
         if (i >= DIV_LSB && i < DIV_LSB + div_w) m[i] = 1'b1;
         if (has_alt && i == ALT_BIT) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mclk_ctrl_reg.sv
module mclk_ctrl_reg #(
   parameter int WORD_W = 32,
   parameter logic [WORD_W-1:0] MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wr_data & MASK;
   end

   // R9: the word written one cycle earlier is what reads back
   p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q == ($past(wr_data) & MASK)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/mclk_src_sel.sv
module mclk_src_sel #(
   parameter int SEL_W   = 2,
   parameter int NUM_SRC = 1 << SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic [SEL_W-1:0]   sel,
   output logic               rise,
   output logic               fall
);

   logic lvl_q, lvl_qq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         lvl_qq <= 1'b0;
      end else begin
         lvl_q  <= src_clk[sel];
         lvl_qq <= lvl_q;
      end
   end

   assign rise = lvl_q & ~lvl_qq;
   assign fall = ~lvl_q & lvl_qq;

endmodule

// File: rtl/mclk_divider.sv
module mclk_divider #(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_field,
   input  logic             rise,
   input  logic             fall,
   output logic             div_out
);

   localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
   localparam logic [DIV_W:0]   TWO1 = (DIV_W+1)'(2);

   logic [DIV_W-1:0] div_act;
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   half;
   logic             term;

   assign half = ({1'b0, div_act} + TWO1) >> 1;
   assign term = (cnt == div_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_act <= '0;
         cnt     <= '0;
         div_out <= 1'b0;
      end else if (!en) begin
         div_act <= div_field;
         cnt     <= '0;
         div_out <= 1'b0;
      end else if (rise) begin
         if (term) begin
            cnt     <= '0;
            div_act <= div_field;
         end else begin
            cnt <= cnt + ONE;
         end
         if (cnt == '0)                  div_out <= 1'b1;
         else if ({1'b0, cnt} == half)   div_out <= 1'b0;
      end else if (fall && div_act == '0) begin
         div_out <= 1'b0;
      end
   end

   // R2: a closed gate leaves the output low
   p_gate_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !div_out);

   // R4: the counter never passes the active terminal value
   p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_act);

   // R7: with the gate open, the ratio changes only on a source edge
   p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rise) |=> $stable(div_act));

   // R8: the output starts a high phase only on a source rising edge
   p_rise_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && rise) |=> !$rose(div_out));

endmodule

// File: rtl/mclk_gen.sv
module mclk_gen #(
   parameter int SEL_W   = 2,
   parameter int DIV_W   = 15,
   parameter bit HAS_ALT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic [3:0]  src_clk,
   input  logic        alt_clk,
   output logic        mclk_out
);
   import mclk_gen_pkg::*;

   localparam int NUM_SRC = 1 << SEL_W;
   localparam logic [WORD_W-1:0] MASK = field_mask(SEL_W, DIV_W, HAS_ALT);

   if (SEL_LSB + SEL_W > EN_BIT) begin : g_bad_sel
      $error("select field overlaps the enable bit");
   end
   if (DIV_LSB + DIV_W > WORD_W) begin : g_bad_div
      $error("divider field does not fit in the control word");
   end
   if (DIV_W < 2) begin : g_bad_divw
      $error("divider must be at least two bits wide");
   end
   if (NUM_SRC != 4) begin : g_bad_src
      $error("source port width assumes four sources");
   end

   logic [WORD_W-1:0] ctrl_q;
   logic              rise, fall, div_out;

   mclk_ctrl_reg #(.WORD_W(WORD_W), .MASK(MASK)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
   );

   mclk_src_sel #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_sel (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
      .sel(ctrl_q[SEL_LSB +: SEL_W]), .rise(rise), .fall(fall)
   );

   mclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q[EN_BIT]),
      .div_field(ctrl_q[DIV_LSB +: DIV_W]),
      .rise(rise), .fall(fall), .div_out(div_out)
   );

   assign rd_data = ctrl_q;

   if (HAS_ALT) begin : g_alt
      assign mclk_out = ctrl_q[ALT_BIT] ? alt_clk : div_out;
   end else begin : g_pass
      logic unused_alt;
      assign unused_alt = alt_clk;
      assign mclk_out   = div_out;
   end

   // R1: control word clear in the first cycle after reset release
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl_q == '0));

endmodule

// File: tb/mclk_gen_test.sv
module mclk_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  src_clk = '0;
   logic        alt_clk = 1'b0;
   logic        mclk_out;

   int total = 0;
   int bad   = 0;
   int hp [4] = '{2, 3, 5, 1};
   int sc [4] = '{0, 0, 0, 0};
   localparam logic [31:0] RB_MASK = 32'hFFFF_C080;

   always #10 clk = ~clk;

   mclk_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_clk(src_clk), .alt_clk(alt_clk), .mclk_out(mclk_out)
   );

   initial begin
      forever begin
         @(negedge clk);
         for (int i = 0; i < 4; i++) begin
            sc[i] = sc[i] + 1;
            if (sc[i] == hp[i]) begin
               src_clk[i] = ~src_clk[i];
               sc[i] = 0;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word(int sel, int dv, bit en, bit alt);
      return (32'(dv) << 17) | (32'(sel) << 14) | (32'(en) << 16) | (32'(alt) << 7);
   endfunction

   function automatic int exp_hi(int sel, int dv);
      int n = dv + 1;
      if (n == 1) return hp[sel];
      return ((n + 1) / 2) * 2 * hp[sel];
   endfunction

   function automatic int exp_per(int sel, int dv);
      return (dv + 1) * 2 * hp[sel];
   endfunction

   task automatic wr_now(input logic [31:0] w);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(input logic [31:0] w);
      @(negedge clk);
      wr_now(w);
   endtask

   task automatic prog(input int sel, input int dv, input bit alt);
      wr(word(0, 0, 1'b0, alt));
      wr(word(sel, dv, 1'b0, alt));
      wr(word(sel, dv, 1'b1, alt));
   endtask

   task automatic wait_rise(input int limit, output int cyc);
      logic p, cur;
      bit r;
      p = mclk_out;
      cyc = 0;
      r = 1'b0;
      while (!r && cyc < limit) begin
         @(negedge clk);
         cur = mclk_out;
         r = cur && !p;
         p = cur;
         cyc++;
      end
      if (!r) cyc = -1;
   endtask

   task automatic measure(input int limit, output int hi, output int per);
      int c, w;
      logic cur;
      hi = -1;
      per = -1;
      wait_rise(limit, w);
      if (w < 0) return;
      c = 0;
      do begin @(negedge clk); c++; cur = mclk_out; end while (cur && c < limit);
      hi = c;
      do begin @(negedge clk); c++; cur = mclk_out; end while (!cur && c < limit);
      per = c;
   endtask

   task automatic run_ratio(input int sel, input int dv, input string tag, input int limit);
      int hi, per;
      prog(sel, dv, 1'b0);
      measure(limit, hi, per);
      chk(hi == exp_hi(sel, dv), {tag, " high"}, hi, exp_hi(sel, dv));
      chk(per == exp_per(sel, dv), {tag, " period"}, per, exp_per(sel, dv));
   endtask

   initial begin
      #(20 * 190000);
      bad++;
      total++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hi, per, c, viol;
      logic [31:0] w;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data == 32'd0, "R1 reset word", int'(rd_data), 0);
      chk(mclk_out == 1'b0, "R1 reset output", int'(mclk_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rd_data == 32'd0, "R1 word after release", int'(rd_data), 0);
      chk(mclk_out == 1'b0, "R1 output after release", int'(mclk_out), 0);

      // R9 readback masking
      for (int i = 0; i < 8; i++) begin
         w = $urandom();
         wr(w);
         @(negedge clk);
         chk(rd_data == (w & RB_MASK), "R9 readback", int'(rd_data), int'(w & RB_MASK));
      end

      // R2 gate closed
      wr(word(3, 3, 1'b0, 1'b0));
      viol = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (mclk_out) viol++;
      end
      chk(viol == 0, "R2 gated idle high samples", viol, 0);

      // R5 pass-through on two sources
      run_ratio(0, 0, "R5 pass src0", 200);
      run_ratio(3, 0, "R5 pass src3", 200);
      // R6 odd, R4 even
      run_ratio(1, 4, "R6 odd ratio 5", 400);
      run_ratio(2, 3, "R4 even ratio 4", 400);
      run_ratio(0, 1, "R6 ratio 2", 400);

      // R3/R4 random sources and ratios
      for (int i = 0; i < 12; i++) begin
         int s, d;
         s = int'($urandom_range(3, 0));
         d = int'($urandom_range(11, 0));
         run_ratio(s, d, $sformatf("R3 R4 random sel=%0d div=%0d", s, d), 1000);
      end

      // R7 ratio rewrite with the gate open
      prog(0, 5, 1'b0);
      wait_rise(200, c);
      wr_now(word(0, 2, 1'b1, 1'b0));
      wait_rise(200, c);
      chk(c + 1 == 24, "R7 running period kept", c + 1, 24);
      measure(200, hi, per);
      chk(hi == 8, "R7 new ratio high", hi, 8);
      chk(per == 12, "R7 new ratio period", per, 12);

      // R8 gate opens while source high: first pulse must be full
      wr(word(2, 0, 1'b0, 1'b0));
      while (src_clk[2] != 1'b1) @(negedge clk);
      @(negedge clk);
      wr_now(word(2, 0, 1'b1, 1'b0));
      measure(200, hi, per);
      chk(hi == 5, "R8 first pulse full length", hi, 5);
      chk(per == 10, "R8 first period", per, 10);

      // R10 output stage
      wr(word(0, 0, 1'b1, 1'b1));
      @(negedge clk);
      alt_clk = 1'b1;
      #1 chk(mclk_out == 1'b1, "R10 alt high", int'(mclk_out), 1);
      @(negedge clk);
      alt_clk = 1'b0;
      #1 chk(mclk_out == 1'b0, "R10 alt low", int'(mclk_out), 0);
      wr(word(0, 0, 1'b0, 1'b0));
      @(negedge clk);
      alt_clk = 1'b1;
      viol = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mclk_out) viol++;
      end
      chk(viol == 0, "R10 divider path selected", viol, 0);
      alt_clk = 1'b0;

      // R11 largest field
      run_ratio(3, 32767, "R11 max ratio", 70000);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule